// File: doc/BRIEF.md
# Two-Stage Serial Clock Generator

This block derives the shift clock of a synchronous serial master from the functional clock. The first stage is a shared prescaler with four uneven ratios: 2, 4, 7 and 10. It emits a one-cycle tick every ratio clocks. The second stage is a postscaler that counts those ticks. It flips the serial clock level every 1, 2 or 4 ticks, which gives a further divide of 2, 4 or 8 across a full serial clock period. The slowest serial clock is therefore the functional clock divided by 80.

The surrounding shift engine requests clocking by holding `xfer_req_i` high for the length of a transfer. It takes its shift and sample moments from the registered rise and fall strobes, which appear in the same cycle as the matching level change on `sclk_o`. A global enable gates the whole generator. A global polarity input selects whether the clock idles low or high.

The prescaler code, postscaler code and polarity are captured when a transfer starts. They are held until the generator goes idle again. Both counters are cleared while idle, so the first edge always comes a fixed number of cycles after the start.

Top module: `uw_sclk_gen`

## Requirements
- R1: After reset, `sclk_o` is 0, both strobes are 0 and `busy_o` is 0.
- R2: `busy_o` rises in the cycle after `gen_en_i` and `xfer_req_i` are both seen high. It falls in the cycle after either of them is seen low.
- R3: Prescaler code 0, 1, 2 or 3 on `pre_sel_i` gives a prescale ratio P of 2, 4, 7 or 10. The postscaler gives a half period of H ticks. The first level change on `sclk_o` comes P*H clocks after `busy_o` rises, and every later change comes P*H clocks after the one before it. The slowest case, code 3 with /8, gives a half period of 40 clocks and a full period of 80 clocks.
- R4: Postscaler code 0, 1 or 2 on `post_sel_i` gives a full-period divide of 2, 4 or 8, which is H = 1, 2 or 4 ticks.
- R5: Postscaler code 3 is reserved and behaves exactly like code 2 (H = 4).
- R6: With `idle_high_i` at 0 the clock idles at 0 and the first edge is a rise. With it at 1 the clock idles at 1 and the first edge is a fall. `sclk_rise_o` is high exactly in the cycle in which `sclk_o` has just gone from 0 to 1, and `sclk_fall_o` exactly in the cycle in which it has just gone from 1 to 0.
- R7: Each strobe lasts a single cycle. The two strobes are never high together, and neither is high while `busy_o` is low. While busy, every change of `sclk_o` comes with a strobe.
- R8: A change to `pre_sel_i` or `post_sel_i` while busy has no effect on the running transfer. It applies from the next start.
- R9: With `gen_en_i` low the generator stays idle even when `xfer_req_i` is high, and `sclk_o` rests at its idle level. Dropping `gen_en_i` during a transfer stops it in the next cycle.
- R10: If a stop is sampled in the same cycle as a pending clock edge, the stop wins. No strobe is issued, and `sclk_o` returns to its idle level as `busy_o` falls.
- R11: A change to `idle_high_i` while busy does not affect `sclk_o` until the generator is idle. The new idle level shows by the second cycle after `busy_o` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gen_en_i | input | 1 | Global generator enable |
| xfer_req_i | input | 1 | Held high while the shift engine wants clocking |
| pre_sel_i | input | 2 | Prescaler code: 0..3 selects 2, 4, 7, 10 |
| post_sel_i | input | 2 | Postscaler code: 0..2 selects /2, /4, /8; 3 acts as /8 |
| idle_high_i | input | 1 | Clock idles high when set |
| sclk_o | output | 1 | Serial clock level |
| sclk_rise_o | output | 1 | One-cycle strobe with a 0 to 1 change of `sclk_o` |
| sclk_fall_o | output | 1 | One-cycle strobe with a 1 to 0 change of `sclk_o` |
| busy_o | output | 1 | Generator is running a transfer |

## Verification
A stop (loss of request or enable) can be sampled in the same cycle as the postscaler completing a half period. The two then compete for the clock register and the strobe registers. The bench provokes this by starting a transfer with a four-cycle half period and dropping the request exactly one cycle before the first edge is due. It then judges the next sample: `busy_o` must be low, `sclk_o` must sit at its idle level and neither strobe may be high. A second overlap, a settings change landing while a transfer is in flight, is judged by the following half period keeping the old length and direction.

// File: rtl/uw_sclk_pkg.sv
package uw_sclk_pkg;

  // Settings captured at the start of a transfer.
  typedef struct packed {
    logic [1:0] pre_code;
    logic [1:0] post_code;
    logic       idle_high;
  } sclk_cfg_t;

  // Highest postscaler stage: half period of 2**POST_TOP ticks.
  localparam logic [1:0] POST_TOP = 2'd2;

  // Reserved codes above the top stage clamp to it.
  function automatic logic [1:0] post_stage(input logic [1:0] code);
    return (code > POST_TOP) ? POST_TOP : code;
  endfunction

endpackage

// File: rtl/uw_sclk_prescale.sv
module uw_sclk_prescale #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] ratio_m1_i,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  assign wrap   = (cnt_q == ratio_m1_i);
  assign tick_o = !clr_i && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uw_sclk_postscale.sv
module uw_sclk_postscale #(
  parameter int HALF_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [HALF_W-1:0] half_m1_i,
  output logic              flip_o
);

  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign flip_o = tick_i && (cnt_q == half_m1_i);
  assign cnt_en = clr_i || tick_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (flip_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uw_sclk_shaper.sv
module uw_sclk_shaper (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic flip_i,
  input  logic pol_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);

  logic phase_q, phase_d;
  logic rise_q, rise_d;
  logic fall_q, fall_d;
  logic next_lvl;

  // Pin level the clock will take after a flip.
  assign next_lvl = ~phase_q ^ pol_i;

  always_comb begin
    phase_d = phase_q;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    if (clr_i) begin
      phase_d = 1'b0;
    end else if (flip_i) begin
      phase_d = ~phase_q;
      rise_d  = next_lvl;
      fall_d  = ~next_lvl;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign sclk_o = phase_q ^ pol_i;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

endmodule

// File: rtl/uw_sclk_gen.sv
module uw_sclk_gen
  import uw_sclk_pkg::*;
#(
  parameter int PRE_R0 = 2,
  parameter int PRE_R1 = 4,
  parameter int PRE_R2 = 7,
  parameter int PRE_R3 = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gen_en_i,
  input  logic       xfer_req_i,
  input  logic [1:0] pre_sel_i,
  input  logic [1:0] post_sel_i,
  input  logic       idle_high_i,
  output logic       sclk_o,
  output logic       sclk_rise_o,
  output logic       sclk_fall_o,
  output logic       busy_o
);

  localparam int PRE_M01 = (PRE_R0 > PRE_R1) ? PRE_R0 : PRE_R1;
  localparam int PRE_M23 = (PRE_R2 > PRE_R3) ? PRE_R2 : PRE_R3;
  localparam int PRE_MAX = (PRE_M01 > PRE_M23) ? PRE_M01 : PRE_M23;
  localparam int CNT_W   = (PRE_MAX > 2) ? $clog2(PRE_MAX) : 1;
  localparam int HALF_W  = (int'(POST_TOP) > 0) ? int'(POST_TOP) : 1;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Transfer state and captured settings.
  logic       go;
  logic       active_q, active_d;
  logic       cfg_en;
  sclk_cfg_t  cfg_q, cfg_d;
  logic       clr;

  assign go     = gen_en_i && xfer_req_i;
  assign clr    = !(active_q && go);
  assign cfg_en = !active_q;

  always_comb begin
    active_d          = go;
    cfg_d.pre_code    = pre_sel_i;
    cfg_d.post_code   = post_sel_i;
    cfg_d.idle_high   = idle_high_i;
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) active_q <= 1'b0;
    else            active_q <= active_d;
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n)  cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // Prescale ratio table, one entry per code.
  logic [CNT_W-1:0] ratio_tab [4];
  for (genvar g = 0; g < 4; g++) begin : g_ratio
    localparam int R = (g == 0) ? PRE_R0 : (g == 1) ? PRE_R1 :
                       (g == 2) ? PRE_R2 : PRE_R3;
    assign ratio_tab[g] = CNT_W'(R - 1);
  end

  logic [CNT_W-1:0]  ratio_m1;
  logic [HALF_W-1:0] half_m1;
  logic [1:0]        stage;

  assign ratio_m1 = ratio_tab[cfg_q.pre_code];
  assign stage    = post_stage(cfg_q.post_code);
  assign half_m1  = {HALF_W{1'b1}} >> (POST_TOP - stage);

  logic tick, flip;

  uw_sclk_prescale #(.CNT_W(CNT_W)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .clr_i      (clr),
    .ratio_m1_i (ratio_m1),
    .tick_o     (tick)
  );

  uw_sclk_postscale #(.HALF_W(HALF_W)) u_post (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .clr_i     (clr),
    .tick_i    (tick),
    .half_m1_i (half_m1),
    .flip_o    (flip)
  );

  uw_sclk_shaper u_shape (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .clr_i  (clr),
    .flip_i (flip),
    .pol_i  (cfg_q.idle_high),
    .sclk_o (sclk_o),
    .rise_o (sclk_rise_o),
    .fall_o (sclk_fall_o)
  );

  assign busy_o = active_q;

endmodule

// File: rtl/uw_sclk_gen_chk.sv
module uw_sclk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic gen_en_i,
  input logic xfer_req_i,
  input logic sclk_o,
  input logic sclk_rise_o,
  input logic sclk_fall_o,
  input logic busy_o
);

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_en_i && xfer_req_i && !busy_o) |=> busy_o);  // R2

  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gen_en_i && xfer_req_i) |=> !busy_o);  // R9

  AST_RISE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise_o |-> (sclk_o && !$past(sclk_o)));  // R6

  AST_FALL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall_o |-> (!sclk_o && $past(sclk_o)));  // R6

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sclk_rise_o && sclk_fall_o));  // R7

  AST_STROBE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(sclk_rise_o || sclk_fall_o));  // R7

  AST_EDGE_STROBED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && (sclk_o != $past(sclk_o))) |->
      (sclk_rise_o || sclk_fall_o));  // R7

endmodule

bind uw_sclk_gen uw_sclk_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gen_en_i    (gen_en_i),
  .xfer_req_i  (xfer_req_i),
  .sclk_o      (sclk_o),
  .sclk_rise_o (sclk_rise_o),
  .sclk_fall_o (sclk_fall_o),
  .busy_o      (busy_o)
);

// File: tb/tb_uw_sclk_gen.sv
`timescale 1ns/1ps
module tb_uw_sclk_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, req, idle_hi;
  logic [1:0] pre, post;
  logic       sclk, rise, fall, busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uw_sclk_gen dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .gen_en_i    (en),
    .xfer_req_i  (req),
    .pre_sel_i   (pre),
    .post_sel_i  (post),
    .idle_high_i (idle_hi),
    .sclk_o      (sclk),
    .sclk_rise_o (rise),
    .sclk_fall_o (fall),
    .busy_o      (busy)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  function automatic int pre_ratio(input logic [1:0] c);
    case (c)
      2'd0: return 2;
      2'd1: return 4;
      2'd2: return 7;
      default: return 10;
    endcase
  endfunction

  function automatic int post_half(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 2;
      default: return 4;
    endcase
  endfunction

  // Wait for the next level change of sclk; check its distance and strobe.
  task automatic measure(input int exp, input string tag);
    int cnt = 0;
    int stray = 0;
    logic prev = sclk;
    do begin
      @(negedge clk);
      cnt++;
      if (sclk == prev && (rise || fall)) stray++;
    end while (sclk == prev && cnt < 300);
    chk(cnt == exp, tag, cnt, exp);
    if (sclk) chk(rise && !fall, "R6 rise strobe", {rise, fall}, 2);
    else      chk(fall && !rise, "R6 fall strobe", {rise, fall}, 1);
    chk(stray == 0, "R7 stray strobe", stray, 0);
  endtask

  task automatic start(input logic [1:0] p, input logic [1:0] q, input logic ih);
    @(negedge clk);
    pre = p; post = q; idle_hi = ih;
    repeat (2) @(negedge clk);
    en = 1'b1; req = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy rise", busy, 1);
  endtask

  task automatic stop(input logic ih);
    req = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R2 busy fall", busy, 0);
    chk(sclk == ih, "R6 idle level after stop", sclk, ih);
  endtask

  task automatic t_reset;
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(!rise && !fall, "R1 strobes", {rise, fall}, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
  endtask

  task automatic t_ratio(input logic [1:0] p, input logic [1:0] q, input logic ih,
                         input string tag);
    int hn = pre_ratio(p) * post_half(q);
    start(p, q, ih);
    chk(sclk == ih, "R6 idle at start", sclk, ih);
    measure(hn, tag);
    chk(sclk == !ih, "R6 first edge direction", sclk, !ih);
    measure(hn, tag);
    @(negedge clk);
    chk(!rise && !fall, "R7 single-cycle strobe", {rise, fall}, 0);
    stop(ih);
  endtask

  task automatic t_enable;
    @(negedge clk);
    en = 1'b0; req = 1'b1; pre = 2'd0; post = 2'd0; idle_hi = 1'b0;
    repeat (8) @(negedge clk);
    chk(busy == 1'b0, "R9 disabled stays idle", busy, 0);
    chk(sclk == 1'b0, "R9 idle level", sclk, 0);
    en = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after enable", busy, 1);
    measure(2, "R9 runs once enabled");
    en = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R9 disable stops", busy, 0);
    chk(sclk == 1'b0, "R9 idle after disable", sclk, 0);
    req = 1'b0;
  endtask

  task automatic t_collide;
    start(2'd0, 2'd1, 1'b0);
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0, "R10 no edge before due", sclk, 0);
    req = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R10 busy low", busy, 0);
    chk(sclk == 1'b0, "R10 idle level wins", sclk, 0);
    chk(!rise && !fall, "R10 no strobe", {rise, fall}, 0);
  endtask

  task automatic t_change;
    start(2'd0, 2'd0, 1'b0);
    pre = 2'd3; post = 2'd2; idle_hi = 1'b1;
    measure(2, "R8 old ratio held");
    chk(sclk == 1'b1, "R11 polarity held while busy", sclk, 1);
    measure(2, "R8 old ratio held");
    req = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R2 busy fall", busy, 0);
    @(negedge clk);
    chk(sclk == 1'b1, "R11 new idle level", sclk, 1);
    req = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R2 restart", busy, 1);
    measure(40, "R8 new ratio at next start");
    chk(sclk == 1'b0, "R11 new polarity first edge falls", sclk, 0);
    stop(1'b1);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; req = 1'b0;
    pre = 2'd0; post = 2'd0; idle_hi = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ratio(2'd0, 2'd0, 1'b0, "R3 ratio 2 /2");
    t_ratio(2'd1, 2'd1, 1'b0, "R4 ratio 4 /4");
    t_ratio(2'd2, 2'd0, 1'b0, "R3 ratio 7 /2");
    t_ratio(2'd3, 2'd2, 1'b0, "R3 slowest ratio 10 /8");
    t_ratio(2'd0, 2'd2, 1'b1, "R6 idle high /8");
    t_ratio(2'd1, 2'd3, 1'b0, "R5 reserved post code");
    t_enable();
    t_collide();
    t_change();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #900000;
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule